// File: doc/BRIEF.md
# Keyed-Feed Watchdog Timer

The block is a watchdog timer on a simple register bus. Each clock cycle it sees at most one access: a write or a read at a byte offset. A fixed divide-by-4 prescaler drives a 24-bit down-counter. Software reloads the counter by writing a two-byte key pair to the feed register. Arming happens only after the enable bit is set and a complete key pair follows it. From then on, an expired counter or a broken key pair produces a one-cycle reset request for the system reset logic. Expiry also sets a sticky timeout flag.

A control state machine has four states. `ST_OFF` moves to `ST_WAIT` on a mode write with the enable bit set (transition *enable*). `ST_WAIT` moves to `ST_ARMED` on a valid feed (transition *arm*). `ST_ARMED` moves to `ST_DONE` on a prescaled tick that finds the counter at zero (transition *expire*). `ST_DONE` is left only through reset. No transition leads back to `ST_OFF`, so enable cannot be withdrawn.

A second machine checks the key pair. `FS_IDLE` moves to `FS_KEY1` on a feed write of 0xAA (transition *first key*). From `FS_KEY1`, any access returns it to `FS_IDLE`. That access counts as *accept* if it is a feed write of 0x55 and as *reject* otherwise.

Register map, byte offsets on `addr`:

| Offset | Content |
|---|---|
| 0x0 | mode: bit 0 enable, bit 1 reset-on-expiry, bit 2 timeout flag (read-only) |
| 0x4 | reload value, 24 bits |
| 0x8 | feed keys; reads return 0 |
| 0xC | current counter value, read-only |

Top module: `keyed_wdt`

## Requirements
- R1: After reset, `reset_req` and `timeout_flag` are 0, mode reads 0, the reload value reads 0xFF and the counter reads 0xFF.
- R2: A write to offset 0x4 keeps bits 23:0 of `wdata`. A value below 0xFF is stored as 0xFF. The write does not change the counter.
- R3: Mode bit 0 (enable) sets on a write of 1 and never clears except by reset. Mode bit 1 (reset-on-expiry) follows every mode write. Bit 2 reads the timeout flag.
- R4: A valid feed is a write of 0xAA to offset 0x8 whose very next access is a write of 0x55 to offset 0x8. It loads the counter from the reload value and restarts the prescaler. It does so in every state except `ST_DONE`.
- R5: The counter decrements once every 4 clock cycles only in `ST_ARMED`; in other states it holds except for a feed load.
- R6: The block arms only on a valid feed made after enable. Broken key pairs before arming have no effect on `reset_req`.
- R7: In `ST_ARMED`, an access that follows a 0xAA feed write and is not a 0x55 feed write raises `reset_req` for one cycle after that access. This includes reads and writes at any offset. Mode bit 1 does not matter, and the timeout flag is not set.
- R8: In `ST_ARMED`, a tick that finds the counter at 0 sets the sticky timeout flag. It also pulses `reset_req` for one cycle, but only if mode bit 1 is 1. With a feed at edge E and reload T, the flag appears after edge E+4(T+1).
- R9: In `ST_DONE` the counter stays at 0, feeds are ignored, and no further reset pulse occurs until reset.
- R10: A read of offset 0xC returns the counter, and a read of offset 0x8 returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | watchdog clock |
| rst_n | input | 1 | active-low asynchronous reset |
| wr_en | input | 1 | write strobe for this cycle |
| rd_en | input | 1 | read strobe for this cycle |
| addr | input | 4 | byte offset of the access |
| wdata | input | 32 | write data |
| rdata | output | 32 | read data, combinational from `addr` |
| reset_req | output | 1 | one-cycle system reset request |
| timeout_flag | output | 1 | sticky expiry flag |

## Verification
The assertions assume that `wr_en` and `rd_en` are never high in the same cycle and that both are low during reset. The bench keeps to this because each access task raises exactly one strobe for exactly one cycle and lowers it before the next task starts. The assertions also assume that two rejected key pairs are always separated by a new 0xAA write, which is how the key machine behaves. The bench applies every broken pair as a separate 0xAA write followed by its offending access.

// File: rtl/keyed_wdt_pkg.sv
package keyed_wdt_pkg;
    typedef enum logic [1:0] {
        ST_OFF,
        ST_WAIT,
        ST_ARMED,
        ST_DONE
    } wdt_state_e;

    typedef enum logic {
        FS_IDLE,
        FS_KEY1
    } feed_state_e;

    localparam logic [3:0] OFS_MODE   = 4'h0;
    localparam logic [3:0] OFS_RELOAD = 4'h4;
    localparam logic [3:0] OFS_FEED   = 4'h8;
    localparam logic [3:0] OFS_COUNT  = 4'hC;

    localparam logic [7:0] KEY_FIRST  = 8'hAA;
    localparam logic [7:0] KEY_SECOND = 8'h55;
endpackage

// File: rtl/keyed_wdt_prescale.sv
module keyed_wdt_prescale #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic tick
);
    localparam int PW = (DIV > 2) ? $clog2(DIV) : 1;
    localparam logic [PW-1:0] LAST = PW'(DIV - 1);

    logic [PW-1:0] phase;

    assign tick = (phase == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            phase <= '0;
        else if (restart || tick)
            phase <= '0;
        else
            phase <= phase + 1'b1;
    end
endmodule

// File: rtl/keyed_wdt_feedseq.sv
module keyed_wdt_feedseq
    import keyed_wdt_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       access,
    input  logic       feed_wr,
    input  logic [7:0] key,
    output logic       feed_ok,
    output logic       feed_bad
);
    feed_state_e fs_q, fs_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            fs_q <= FS_IDLE;
        else
            fs_q <= fs_d;
    end

    always_comb begin
        fs_d     = fs_q;
        feed_ok  = 1'b0;
        feed_bad = 1'b0;
        unique case (fs_q)
            FS_IDLE: begin
                if (feed_wr && key == KEY_FIRST)
                    fs_d = FS_KEY1;
            end
            FS_KEY1: begin
                if (access) begin
                    fs_d = FS_IDLE;
                    if (feed_wr && key == KEY_SECOND)
                        feed_ok = 1'b1;
                    else
                        feed_bad = 1'b1;
                end
            end
        endcase
    end
endmodule

// File: rtl/keyed_wdt_counter.sv
module keyed_wdt_counter #(
    parameter int CNT_W    = 24,
    parameter int INIT_VAL = 255
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             dec,
    output logic [CNT_W-1:0] cnt,
    output logic             at_zero
);
    assign at_zero = (cnt == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= CNT_W'(INIT_VAL);
        else if (load)
            cnt <= load_val;
        else if (dec && !at_zero)
            cnt <= cnt - 1'b1;
    end
endmodule

// File: rtl/keyed_wdt.sv
module keyed_wdt
    import keyed_wdt_pkg::*;
#(
    parameter int ADDR_W     = 4,
    parameter int DATA_W     = 32,
    parameter int CNT_W      = 24,
    parameter int PRE_DIV    = 4,
    parameter int RELOAD_MIN = 255
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              reset_req,
    output logic              timeout_flag
);
    localparam logic [CNT_W-1:0] MIN_V = CNT_W'(RELOAD_MIN);

    wdt_state_e       state, state_d;
    logic [CNT_W-1:0] reload_q;
    logic [CNT_W-1:0] cnt;
    logic             at_zero, tick;
    logic             rst_on_exp;
    logic             feed_ok, feed_bad;
    logic             do_load, do_dec, expire;
    logic             mode_wr, reload_wr, feed_wr;

    assign mode_wr   = wr_en && (addr == ADDR_W'(OFS_MODE));
    assign reload_wr = wr_en && (addr == ADDR_W'(OFS_RELOAD));
    assign feed_wr   = wr_en && (addr == ADDR_W'(OFS_FEED));

    keyed_wdt_feedseq u_feed (
        .clk      (clk),
        .rst_n    (rst_n),
        .access   (wr_en || rd_en),
        .feed_wr  (feed_wr),
        .key      (wdata[7:0]),
        .feed_ok  (feed_ok),
        .feed_bad (feed_bad)
    );

    keyed_wdt_prescale #(.DIV(PRE_DIV)) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (do_load),
        .tick    (tick)
    );

    keyed_wdt_counter #(.CNT_W(CNT_W), .INIT_VAL(RELOAD_MIN)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (do_load),
        .load_val (reload_q),
        .dec      (do_dec),
        .cnt      (cnt),
        .at_zero  (at_zero)
    );

    assign do_load = feed_ok && (state != ST_DONE);
    assign do_dec  = (state == ST_ARMED) && tick && !do_load;
    assign expire  = (state == ST_ARMED) && tick && at_zero && !feed_ok;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= ST_OFF;
        else
            state <= state_d;
    end

    always_comb begin
        state_d = state;
        unique case (state)
            ST_OFF:   if (mode_wr && wdata[0]) state_d = ST_WAIT;
            ST_WAIT:  if (feed_ok)             state_d = ST_ARMED;
            ST_ARMED: if (expire)              state_d = ST_DONE;
            ST_DONE:  state_d = ST_DONE;
        endcase
    end

    // outputs and configuration
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            reset_req    <= 1'b0;
            timeout_flag <= 1'b0;
            rst_on_exp   <= 1'b0;
            reload_q     <= MIN_V;
        end else begin
            reset_req    <= (expire && rst_on_exp) ||
                            (feed_bad && state == ST_ARMED);
            timeout_flag <= timeout_flag || expire;
            if (mode_wr)
                rst_on_exp <= wdata[1];
            if (reload_wr)
                reload_q <= (wdata[CNT_W-1:0] < MIN_V) ? MIN_V : wdata[CNT_W-1:0];
        end
    end

    always_comb begin
        rdata = '0;
        case (addr)
            ADDR_W'(OFS_MODE):   rdata[2:0] = {timeout_flag, rst_on_exp, state != ST_OFF};
            ADDR_W'(OFS_RELOAD): rdata[CNT_W-1:0] = reload_q;
            ADDR_W'(OFS_COUNT):  rdata[CNT_W-1:0] = cnt;
            default:             rdata = '0;
        endcase
    end
endmodule

// File: rtl/keyed_wdt_chk.sv
module keyed_wdt_chk
    import keyed_wdt_pkg::*;
#(
    parameter int CNT_W      = 24,
    parameter int RELOAD_MIN = 255
) (
    input logic             clk,
    input logic             rst_n,
    input wdt_state_e       state,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] reload_q,
    input logic             tick,
    input logic             feed_ok,
    input logic             reset_req,
    input logic             timeout_flag
);
    // R2
    reload_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reload_q >= CNT_W'(RELOAD_MIN));

    // R3
    enable_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_OFF) |=> (state != ST_OFF));

    // R5
    hold_unarmed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_ARMED && !feed_ok) |=> $stable(cnt));

    // R5
    step_armed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ARMED && tick && cnt != '0 && !feed_ok) |=> (cnt == $past(cnt) - 1'b1));

    // R7
    req_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(reset_req) |-> ($past(state) == ST_ARMED));

    // R8
    req_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reset_req |=> !reset_req);

    // R8
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_flag |=> timeout_flag);

    // R9
    done_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DONE) |=> (state == ST_DONE && cnt == '0));
endmodule

bind keyed_wdt keyed_wdt_chk #(.CNT_W(CNT_W), .RELOAD_MIN(RELOAD_MIN)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .state        (state),
    .cnt          (cnt),
    .reload_q     (reload_q),
    .tick         (tick),
    .feed_ok      (feed_ok),
    .reset_req    (reset_req),
    .timeout_flag (timeout_flag)
);

// File: tb/test_keyed_wdt.sv
module test_keyed_wdt;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [3:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        reset_req;
    logic        timeout_flag;

    int checks = 0;
    int fails  = 0;
    int pulses = 0;

    always #5 clk = ~clk;

    keyed_wdt i_keyed_wdt (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en        (wr_en),
        .rd_en        (rd_en),
        .addr         (addr),
        .wdata        (wdata),
        .rdata        (rdata),
        .reset_req    (reset_req),
        .timeout_flag (timeout_flag)
    );

    always @(negedge clk) if (reset_req) pulses++;

    // {write, offset, data, expected read}
    localparam logic [68:0] VEC [0:11] = '{
        {1'b1, 4'h4, 32'h0000_0010, 32'h0},
        {1'b0, 4'h4, 32'h0,         32'h0000_00FF},
        {1'b1, 4'h4, 32'hFF12_3456, 32'h0},
        {1'b0, 4'h4, 32'h0,         32'h0012_3456},
        {1'b0, 4'hC, 32'h0,         32'h0000_00FF},
        {1'b1, 4'h0, 32'h0000_0002, 32'h0},
        {1'b0, 4'h0, 32'h0,         32'h0000_0002},
        {1'b1, 4'h0, 32'h0000_0000, 32'h0},
        {1'b0, 4'h0, 32'h0,         32'h0000_0000},
        {1'b1, 4'h4, 32'h0000_0100, 32'h0},
        {1'b0, 4'h4, 32'h0,         32'h0000_0100},
        {1'b0, 4'h8, 32'h0,         32'h0000_0000}
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    endtask

    task automatic bus_wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic bus_rd(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        #1 d = rdata;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic feed();
        bus_wr(4'h8, 32'hAA);
        bus_wr(4'h8, 32'h55);
    endtask

    task automatic expect_rd(input logic [3:0] a, input logic [31:0] e, input string req);
        logic [31:0] v;
        bus_rd(a, v);
        check(v == e, req, v, e);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wait_flag(output int n);
        n = 0;
        while (!timeout_flag && n < 5000) begin
            @(negedge clk);
            n++;
        end
    endtask

    initial begin
        #2_000_000;
        fails++;
        $display("FAIL watchdog: run hung, actual 0 expected 1");
        finish_run();
    end

    initial begin
        int n;
        int p0;
        do_reset();

        // R1 reset state
        check(reset_req == 1'b0, "R1", reset_req, 0);
        check(timeout_flag == 1'b0, "R1", timeout_flag, 0);
        expect_rd(4'h0, 32'h0, "R1");
        expect_rd(4'h4, 32'hFF, "R1");
        expect_rd(4'hC, 32'hFF, "R1");

        // register vectors: R2 reload, R3 mode, R10 reads
        for (int i = 0; i < 12; i++) begin
            logic [31:0] v;
            if (VEC[i][68]) begin
                bus_wr(VEC[i][67:64], VEC[i][63:32]);
            end else begin
                bus_rd(VEC[i][67:64], v);
                case (VEC[i][67:64])
                    4'h0:    check(v == VEC[i][31:0], "R3", v, VEC[i][31:0]);
                    4'h4:    check(v == VEC[i][31:0], "R2", v, VEC[i][31:0]);
                    default: check(v == VEC[i][31:0], "R10", v, VEC[i][31:0]);
                endcase
            end
        end

        // R6 broken pair while disabled: no request
        bus_wr(4'h8, 32'hAA);
        bus_wr(4'h8, 32'h12);
        check(reset_req == 1'b0, "R6", reset_req, 0);

        // R4 valid feed while disabled reloads only; R5 holds when unarmed
        feed();
        expect_rd(4'hC, 32'h100, "R4");
        repeat (40) @(negedge clk);
        expect_rd(4'hC, 32'h100, "R5");

        // R3 enable plus reset-on-expiry
        bus_wr(4'h0, 32'h3);
        expect_rd(4'h0, 32'h3, "R3");

        // R6 enabled but not armed: aborted pair gives no request
        bus_wr(4'h8, 32'hAA);
        expect_rd(4'h0, 32'h3, "R6");
        check(reset_req == 1'b0, "R6", reset_req, 0);

        // R3 enable cannot be cleared
        bus_wr(4'h0, 32'h0);
        expect_rd(4'h0, 32'h1, "R3");
        bus_wr(4'h0, 32'h3);

        // R4 arm and reload; R5 decrement rate
        bus_wr(4'h4, 32'hFF);
        feed();
        expect_rd(4'hC, 32'hFF, "R4");
        feed();
        repeat (40) @(negedge clk);
        expect_rd(4'hC, 32'hF5, "R5");

        // R8 regular feeding keeps it alive
        for (int k = 0; k < 3; k++) begin
            repeat (600) @(negedge clk);
            feed();
        end
        #1;
        check(timeout_flag == 1'b0, "R8", timeout_flag, 0);
        check(pulses == 0, "R8", pulses, 0);

        // R8 expiry timing with reset-on-expiry set
        feed();
        wait_flag(n);
        check(n == 1024, "R8", n, 1024);
        check(reset_req == 1'b1, "R8", reset_req, 1);
        @(negedge clk);
        check(reset_req == 1'b0, "R8", reset_req, 0);

        // R9 expired state frozen
        repeat (50) @(negedge clk);
        expect_rd(4'hC, 32'h0, "R9");
        feed();
        expect_rd(4'hC, 32'h0, "R9");
        bus_wr(4'h8, 32'hAA);
        bus_wr(4'h8, 32'h00);
        #1;
        check(pulses == 1, "R9", pulses, 1);
        expect_rd(4'h0, 32'h7, "R3");

        // R1 reset clears everything again
        do_reset();
        check(timeout_flag == 1'b0, "R1", timeout_flag, 0);
        expect_rd(4'h0, 32'h0, "R1");

        // R7 faults while armed, reset-on-expiry off
        bus_wr(4'h4, 32'h100);
        bus_wr(4'h0, 32'h1);
        feed();
        bus_wr(4'h8, 32'hAA);
        bus_wr(4'h8, 32'hAA);
        check(reset_req == 1'b1, "R7", reset_req, 1);
        @(negedge clk);
        check(reset_req == 1'b0, "R7", reset_req, 0);
        bus_wr(4'h8, 32'hAA);
        begin
            logic [31:0] v;
            bus_rd(4'h4, v);
        end
        check(reset_req == 1'b1, "R7", reset_req, 1);
        bus_wr(4'h8, 32'hAA);
        bus_wr(4'h4, 32'h100);
        check(reset_req == 1'b1, "R7", reset_req, 1);
        check(timeout_flag == 1'b0, "R7", timeout_flag, 0);

        // R8 expiry without reset-on-expiry: flag only
        #1 p0 = pulses;
        feed();
        wait_flag(n);
        check(n == 1028, "R8", n, 1028);
        check(reset_req == 1'b0, "R8", reset_req, 0);
        @(negedge clk);
        #1;
        check(pulses == p0, "R8", pulses, p0);

        finish_run();
    end
endmodule